// File: doc/BRIEF.md
# Configurable UART Framing Engine

This block is the serial heart of a UART: a transmitter that turns one character at a time into an asynchronous line frame, and a receiver that watches the incoming line, rebuilds characters and reports whether each one arrived intact. Both halves advance on a clock-enable pulse `tick` that the surrounding logic generates at eight times the bit rate. Bus registers, interrupt logic and the baud generator are outside the block.

The frame format is set by static control pins. These pins choose a word length of 5 to 8 bits, one or two stop bits, and one of five parity modes: none, odd, even, forced-one or forced-zero. The transmitter takes characters from a transmit FIFO over a valid/ready stream and asserts `tx_ready` only while it is idle. When flow control is enabled, `tx_ready` also needs `cts` high. The receiver delivers each character together with one combined error bit over a valid/ready stream toward a receive FIFO. The serial line cannot be stalled. A character held by a low `rx_ready` stays stable until it is accepted, and any frame that completes while the slot is full is discarded. A loopback control feeds the transmitter output into the receiver in place of the `rxd` pin.

Top module: `uart_frame_core`

## Requirements
- R1: Each serial bit lasts exactly 8 `tick` pulses. `txd` is 1 whenever the transmitter is idle, including after reset.
- R2: `cfg_len` selects the word length: 0 = 5, 1 = 6, 2 = 7, 3 = 8 data bits. Data bits are sent least significant first. On receive, `rx_data` bits above the word length read 0.
- R3: With `cfg_two_stop` = 1 the frame ends with two stop bits at 1. With `cfg_two_stop` = 0 it ends with one.
- R4: `cfg_parity` sets the bit that follows the data. 0 = no parity bit, 4 = odd (data ones plus parity bit give an odd count), 6 = even, 5 = always 1, 7 = always 0. Codes 1 to 3 act as no parity.
- R5: With `cfg_flow_en` = 1 and `cts` = 0, no new character is accepted and `txd` stays high. With `cfg_flow_en` = 0, `cts` has no effect.
- R6: With `cfg_loop_en` = 1 the receiver listens to the transmitter output and ignores `rxd`.
- R7: A receive frame starts on a high-to-low line transition seen at a tick. The line is checked again at the fourth tick of the start bit, and if it is high the frame is abandoned with nothing delivered. Later bits are sampled at their middle tick.
- R8: `rx_err` is 1 for a character whose parity bit mismatches, whose stop bit reads 0, or which is all zero including the stop bit (break). Otherwise it is 0.
- R9: A character is accepted on a clock with `tx_valid` and `tx_ready` both high. `tx_ready` is 0 from the next clock until the last stop bit ends.
- R10: While `rx_valid` is 1 and `rx_ready` is 0, `rx_valid`, `rx_data` and `rx_err` hold. A frame that completes during that time is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Enable pulse at eight times the bit rate |
| cfg_len | input | 2 | Word length code |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_parity | input | 3 | Parity mode code |
| cfg_flow_en | input | 1 | Gate transmit starts with `cts` |
| cfg_loop_en | input | 1 | Internal loopback |
| cts | input | 1 | Clear to send, active high |
| tx_valid | input | 1 | Transmit character offered |
| tx_ready | output | 1 | Transmitter can take a character |
| tx_data | input | 8 | Transmit character |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_valid | output | 1 | Received character available |
| rx_ready | input | 1 | Receive FIFO can take the character |
| rx_data | output | 8 | Received character |
| rx_err | output | 1 | Combined parity, framing or break error |

## Verification
The bound checker watches the stream rules on every cycle. It checks that the line is high whenever the transmitter offers `tx_ready`, that `tx_ready` drops right after an accept, and that a held receive character neither changes nor drops without `rx_ready`. Bit ordering, the parity values, stop-bit counts, word lengths, false-start rejection, error detection and loopback cover whole frames, so only the bench scenarios can show them. The bench decodes `txd` at mid-bit and compares every delivered receive character against a queue of expectations.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;
  localparam int CHAR_W  = 8;
  localparam int LEN_W   = 2;
  localparam int PAR_W   = 3;
  localparam int MIN_LEN = 5;
  localparam int SLOT_MAX = 1 + CHAR_W + 1 + 2;

  localparam logic [PAR_W-1:0] PAR_ODD   = 3'd4;
  localparam logic [PAR_W-1:0] PAR_ONE   = 3'd5;
  localparam logic [PAR_W-1:0] PAR_EVEN  = 3'd6;
  localparam logic [PAR_W-1:0] PAR_ZERO  = 3'd7;

  function automatic int word_bits(input logic [LEN_W-1:0] code);
    return MIN_LEN + int'(code);
  endfunction

  // Bit that follows the data for a given mode; data above the length must be 0.
  function automatic logic parity_of(input logic [CHAR_W-1:0] d, input logic [PAR_W-1:0] mode);
    case (mode)
      PAR_ODD:  return ~^d;
      PAR_EVEN: return ^d;
      PAR_ONE:  return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/uart_tx_ser.sv
module uart_tx_ser
  import uart_frame_pkg::*;
#(
  parameter int OS_RATE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [LEN_W-1:0]  len_code,
  input  logic              two_stop,
  input  logic [PAR_W-1:0]  par_mode,
  input  logic              flow_en,
  input  logic              cts,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  output logic              txd
);
  localparam int CNT_W  = $clog2(OS_RATE);
  localparam int SLOT_W = $clog2(SLOT_MAX + 1);

  logic              busy;
  logic [SLOT_MAX-1:0] shift_q, frame_d;
  logic [SLOT_W-1:0] slots_left, slots_d;
  logic [CNT_W-1:0]  tcnt;
  logic [CHAR_W-1:0] masked;
  int                nd;

  always_comb begin
    nd      = word_bits(len_code);
    frame_d = '1;
    frame_d[0] = 1'b0;
    masked  = '0;
    for (int i = 0; i < CHAR_W; i++) begin
      if (i < nd) begin
        masked[i]    = in_data[i];
        frame_d[i+1] = in_data[i];
      end
    end
    if (par_mode[2]) frame_d[nd+1] = parity_of(masked, par_mode);
    slots_d = SLOT_W'(1 + nd + int'(par_mode[2]) + 1 + int'(two_stop));
  end

  assign in_ready = !busy && (!flow_en || cts);
  assign txd      = busy ? shift_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      shift_q    <= '1;
      slots_left <= '0;
      tcnt       <= '0;
    end else if (in_valid && in_ready) begin
      busy       <= 1'b1;
      shift_q    <= frame_d;
      slots_left <= slots_d;
      tcnt       <= '0;
    end else if (busy && tick) begin
      if (tcnt == CNT_W'(OS_RATE - 1)) begin
        tcnt       <= '0;
        shift_q    <= {1'b1, shift_q[SLOT_MAX-1:1]};
        slots_left <= slots_left - 1'b1;
        if (slots_left == SLOT_W'(1)) busy <= 1'b0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_frame_pkg::*;
#(
  parameter int OS_RATE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic [LEN_W-1:0]  len_code,
  input  logic              two_stop,
  input  logic [PAR_W-1:0]  par_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_err
);
  localparam int CNT_W  = $clog2(OS_RATE);
  localparam int SLOT_W = $clog2(SLOT_MAX + 1);
  localparam int MID    = OS_RATE / 2;

  logic              active, prev_line, perr, ferr;
  logic [CNT_W-1:0]  tcnt;
  logic [SLOT_W-1:0] pos;
  logic [LEN_W-1:0]  len_s;
  logic              two_s;
  logic [PAR_W-1:0]  par_s;
  logic [CHAR_W-1:0] data_q;
  int                nd_s, last_s;

  always_comb begin
    nd_s   = word_bits(len_s);
    last_s = nd_s + 1 + int'(par_s[2]) + int'(two_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      prev_line <= 1'b1;
      perr      <= 1'b0;
      ferr      <= 1'b0;
      tcnt      <= '0;
      pos       <= '0;
      len_s     <= '0;
      two_s     <= 1'b0;
      par_s     <= '0;
      data_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_err   <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (tick) begin
        if (!active) begin
          prev_line <= line;
          if (prev_line && !line) begin
            active <= 1'b1;
            tcnt   <= CNT_W'(1);
            pos    <= '0;
            len_s  <= len_code;
            two_s  <= two_stop;
            par_s  <= par_mode;
            data_q <= '0;
            perr   <= 1'b0;
            ferr   <= 1'b0;
          end
        end else begin
          tcnt <= (tcnt == CNT_W'(OS_RATE - 1)) ? '0 : tcnt + 1'b1;
          if (tcnt == CNT_W'(MID)) begin
            pos <= pos + 1'b1;
            if (pos == '0) begin
              if (line) begin
                active    <= 1'b0;
                prev_line <= 1'b1;
              end
            end else if (int'(pos) <= nd_s) begin
              for (int i = 0; i < CHAR_W; i++)
                if (int'(pos) == i + 1) data_q[i] <= line;
            end else if (par_s[2] && int'(pos) == nd_s + 1) begin
              perr <= (line != parity_of(data_q, par_s));
            end else if (!line) begin
              ferr <= 1'b1;
            end
            if (int'(pos) == last_s) begin
              active    <= 1'b0;
              prev_line <= line;
              if (!out_valid || out_ready) begin
                out_valid <= 1'b1;
                out_data  <= data_q;
                out_err   <= perr | ferr | !line;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_frame_core.sv
module uart_frame_core
  import uart_frame_pkg::*;
#(
  parameter int OS_RATE     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_two_stop,
  input  logic [PAR_W-1:0]  cfg_parity,
  input  logic              cfg_flow_en,
  input  logic              cfg_loop_en,
  input  logic              cts,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [CHAR_W-1:0] tx_data,
  output logic              txd,
  input  logic              rxd,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_err
);
  logic                   tx_line;
  logic                   rx_src;
  logic [SYNC_STAGES-1:0] sync_q;

  uart_tx_ser #(.OS_RATE(OS_RATE)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .len_code(cfg_len), .two_stop(cfg_two_stop), .par_mode(cfg_parity),
    .flow_en(cfg_flow_en), .cts(cts),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .txd(tx_line)
  );

  assign txd    = tx_line;
  assign rx_src = cfg_loop_en ? tx_line : rxd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_src};
  end

  uart_rx_deser #(.OS_RATE(OS_RATE)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .line(sync_q[SYNC_STAGES-1]),
    .len_code(cfg_len), .two_stop(cfg_two_stop), .par_mode(cfg_parity),
    .out_valid(rx_valid), .out_ready(rx_ready),
    .out_data(rx_data), .out_err(rx_err)
  );
endmodule

// File: rtl/uart_frame_core_chk.sv
module uart_frame_core_chk
  import uart_frame_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              txd,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [CHAR_W-1:0] rx_data,
  input logic              rx_err
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_err)));

  assert_rx_drop_only_on_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_valid) |-> $past(rx_ready));
endmodule

bind uart_frame_core uart_frame_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_err(rx_err)
);

// File: tb/sim_uart_frame_core.sv
`timescale 1ns/1ps
module sim_uart_frame_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [1:0] tdiv = '0;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_two_stop = 1'b0;
  logic [2:0] cfg_parity = 3'd0;
  logic cfg_flow_en = 1'b0, cfg_loop_en = 1'b0, cts = 1'b1;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic rxd = 1'b1, rx_ready = 1'b1;
  logic tx_ready, txd, rx_valid, rx_err;
  logic [7:0] rx_data;

  int checks = 0, fails = 0, rx_seen = 0;
  logic [7:0] exp_data[$];
  logic       exp_err[$];
  string      exp_tag[$];

  always #2.5 clk = ~clk;
  always @(negedge clk) begin
    tdiv <= tdiv + 1'b1;
    tick <= (tdiv == 2'd3);
  end

  uart_frame_core u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_len(cfg_len), .cfg_two_stop(cfg_two_stop),
    .cfg_parity(cfg_parity), .cfg_flow_en(cfg_flow_en), .cfg_loop_en(cfg_loop_en), .cts(cts),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .txd(txd), .rxd(rxd),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_err(rx_err)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference for received characters: compared on every accepted beat.
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      rx_seen++;
      if (exp_data.size() == 0) begin
        check("R7", "unexpected rx char", {23'd0, rx_err, rx_data}, 32'hFFFF);
      end else begin
        check(exp_tag[0], "rx char", {23'd0, rx_err, rx_data}, {23'd0, exp_err[0], exp_data[0]});
        void'(exp_data.pop_front()); void'(exp_err.pop_front()); void'(exp_tag.pop_front());
      end
    end
  end

  function automatic int build_frame(input logic [7:0] d, input logic [1:0] len, input logic [2:0] par,
                                     input logic two, output logic [11:0] bits);
    int nd, n, ones;
    nd = 5 + int'(len); bits = '1; bits[0] = 1'b0; n = 1; ones = 0;
    for (int i = 0; i < nd; i++) begin bits[n] = d[i]; ones += int'(d[i]); n++; end
    case (par)
      3'd4: begin bits[n] = (ones % 2 == 0); n++; end
      3'd6: begin bits[n] = (ones % 2 == 1); n++; end
      3'd5: begin bits[n] = 1'b1; n++; end
      3'd7: begin bits[n] = 1'b0; n++; end
      default: ;
    endcase
    return n + 1 + int'(two);
  endfunction

  function automatic logic [7:0] mask_len(input logic [7:0] d, input logic [1:0] len);
    return d & 8'(( 1 << (5 + int'(len))) - 1);
  endfunction

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic send_tx(input logic [7:0] d);
    @(negedge clk); tx_valid = 1'b1; tx_data = d;
    @(posedge clk);
    while (!tx_ready) @(posedge clk);
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic capture(input int n, output logic [11:0] got);
    got = '1;
    do wait_ticks(1); while (txd !== 1'b0);
    wait_ticks(4); got[0] = txd;
    for (int i = 1; i < n; i++) begin wait_ticks(8); got[i] = txd; end
  endtask

  task automatic tx_case(input string req, input logic [7:0] d, input logic [1:0] len,
                         input logic [2:0] par, input logic two);
    logic [11:0] expb, got;
    int n;
    cfg_len = len; cfg_parity = par; cfg_two_stop = two;
    n = build_frame(d, len, par, two, expb);
    fork
      send_tx(d);
      capture(n, got);
    join
    check(req, "txd frame", {20'd0, got}, {20'd0, expb});
  endtask

  task automatic loop_case(input string req, input logic [7:0] d, input logic [1:0] len,
                           input logic [2:0] par, input logic two);
    cfg_len = len; cfg_parity = par; cfg_two_stop = two;
    exp_data.push_back(mask_len(d, len)); exp_err.push_back(1'b0); exp_tag.push_back(req);
    send_tx(d);
    wait_ticks(8 * 13);
  endtask

  task automatic drive_rx(input logic [11:0] bits, input int n, input int tail_low);
    for (int i = 0; i < n; i++) begin rxd = bits[i]; wait_ticks(8); end
    if (tail_low > 0) wait_ticks(tail_low);
    rxd = 1'b1;
    wait_ticks(16);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [11:0] fb;
    int n, bad, seen0;
    repeat (10) @(negedge clk);
    check("R1", "reset txd", {31'd0, txd}, 32'd1);
    check("R9", "reset tx_ready", {31'd0, tx_ready}, 32'd1);
    check("R10", "reset rx_valid", {31'd0, rx_valid}, 32'd0);
    rst_n = 1'b1;
    wait_ticks(4);

    // Transmit framing across lengths, stop counts and parity modes
    tx_case("R1 R2 8N1", 8'hA5, 2'd3, 3'd0, 1'b0);
    tx_case("R2 R4 5-bit odd", 8'hFB, 2'd0, 3'd4, 1'b0);
    tx_case("R3 R4 7-bit even two-stop", 8'h3C, 2'd2, 3'd6, 1'b1);
    tx_case("R4 6-bit forced-one", 8'h2A, 2'd1, 3'd5, 1'b0);
    tx_case("R3 R4 8-bit forced-zero two-stop", 8'h81, 2'd3, 3'd7, 1'b1);
    tx_case("R4 code 2 acts as none", 8'h5E, 2'd3, 3'd2, 1'b0);

    // Loopback: rxd held low is ignored
    cfg_loop_en = 1'b1; @(negedge clk); rxd = 1'b0;
    loop_case("R6 R2 8N1 loopback", 8'hC3, 2'd3, 3'd0, 1'b0);
    loop_case("R6 R2 5-bit upper bits zero", 8'hFF, 2'd0, 3'd6, 1'b1);
    loop_case("R6 R4 6-bit odd", 8'h15, 2'd1, 3'd4, 1'b0);
    loop_case("R6 R4 7-bit forced-zero", 8'h7F, 2'd2, 3'd7, 1'b0);
    check("R6", "loopback queue drained", exp_data.size(), 0);
    rxd = 1'b1; @(negedge clk); cfg_loop_en = 1'b0;
    wait_ticks(4);

    // External receive with even parity, one stop
    cfg_len = 2'd3; cfg_parity = 3'd6; cfg_two_stop = 1'b0;
    n = build_frame(8'h5A, 2'd3, 3'd6, 1'b0, fb);
    exp_data.push_back(8'h5A); exp_err.push_back(1'b0); exp_tag.push_back("R7 good frame");
    drive_rx(fb, n, 0);
    fb[9] = ~fb[9];
    exp_data.push_back(8'h5A); exp_err.push_back(1'b1); exp_tag.push_back("R8 parity error");
    drive_rx(fb, n, 0);
    n = build_frame(8'h33, 2'd3, 3'd6, 1'b0, fb); fb[10] = 1'b0;
    exp_data.push_back(8'h33); exp_err.push_back(1'b1); exp_tag.push_back("R8 stop low");
    drive_rx(fb, n, 0);
    exp_data.push_back(8'h00); exp_err.push_back(1'b1); exp_tag.push_back("R8 break");
    drive_rx(12'h000, n, 16);
    cfg_len = 2'd1; cfg_parity = 3'd5;
    n = build_frame(8'h21, 2'd1, 3'd5, 1'b0, fb); fb[7] = 1'b0;
    exp_data.push_back(8'h21); exp_err.push_back(1'b1); exp_tag.push_back("R8 R4 forced-one mismatch");
    drive_rx(fb, n, 0);
    check("R8", "rx queue drained", exp_data.size(), 0);

    // False start: low for two ticks only
    seen0 = rx_seen;
    rxd = 1'b0; wait_ticks(2); rxd = 1'b1;
    wait_ticks(100);
    check("R7", "false start delivers nothing", rx_seen - seen0, 0);

    // Flow control
    cfg_len = 2'd3; cfg_parity = 3'd0;
    cfg_flow_en = 1'b1; cts = 1'b0;
    @(negedge clk); tx_valid = 1'b1; tx_data = 8'h96; bad = 0;
    repeat (80) begin @(negedge clk); if (tx_ready || !txd) bad++; end
    check("R5", "blocked while cts low", bad, 0);
    tx_valid = 1'b0; cts = 1'b1;
    tx_case("R5 sends after cts high", 8'h96, 2'd3, 3'd0, 1'b0);
    cfg_flow_en = 1'b0; cts = 1'b0;
    wait_ticks(16);
    check("R5", "cts ignored when disabled", {31'd0, tx_ready}, 32'd1);
    tx_case("R5 sends with cts low, flow off", 8'h4D, 2'd3, 3'd0, 1'b0);
    cts = 1'b1;
    wait_ticks(16);

    // Receive back-pressure: first frame held, second dropped
    cfg_loop_en = 1'b1;
    @(posedge clk); #1 rx_ready = 1'b0;
    send_tx(8'h11); send_tx(8'h22);
    wait_ticks(8 * 14);
    check("R10", "held valid", {31'd0, rx_valid}, 32'd1);
    check("R10", "held data", {24'd0, rx_data}, 32'h11);
    exp_data.push_back(8'h11); exp_err.push_back(1'b0); exp_tag.push_back("R10 held char");
    @(posedge clk); #1 rx_ready = 1'b1;
    wait_ticks(4);
    check("R10", "second frame discarded", {31'd0, rx_valid}, 32'd0);
    check("R10", "queue drained", exp_data.size(), 0);
    cfg_loop_en = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule